// File: doc/BRIEF.md
# Two-Way Interleaved Word Store

This block is a word store built from four synchronous banks arranged as two bank pairs. Within a pair, even word addresses live in one bank and odd word addresses in the other. A run of consecutive words therefore alternates between the two banks. This lets the block fetch two sequential words in a single cycle, one from each bank.

Each 48-bit word is held as a low and a high 24-bit half. On write, each half is given its own parity bit. On read, each half is checked against its parity bit, so one stored cell is 50 bits wide.

Requests use a valid/ready handshake. A request is either a single-word write, a single-word read or a paired read of two consecutive words. Read results come back in the cycle after the request is accepted, together with a parity-error flag for each half. The highest address bit picks the bank pair and the lowest address bit picks the bank within the pair. The bits in between form the row inside the bank. With ADDR_W set to 14, the store holds 16384 words, which is 32 pages of 512 words.

Top module: `icore_store`

## Requirements
- R1: While rst_n is low, rsp_valid and req_ready are 0. req_ready is 1 from the first clock edge after reset is released and stays 1 from then on.
- R2: A request with req_valid=1, req_ready=1 and req_write=1 stores req_wdata at req_addr. A write produces no response: rsp_valid is 0 in the following cycle.
- R3: An accepted single read (req_write=0, req_pair=0) sets rsp_valid=1 in the next cycle. In that cycle rsp_data0 holds the word at req_addr, rsp_data1 is 0 and rsp_perr[3:2] is 0.
- R4: An accepted paired read (req_pair=1) from an even address n returns word n on rsp_data0 and word n+1 on rsp_data1, both in the next cycle.
- R5: A paired read from an odd address n also returns word n on rsp_data0 and word n+1 on rsp_data1. Here word n comes from the odd bank and word n+1 from the even bank at the following row.
- R6: A paired read at the last address of the lower bank pair returns the first word of the upper pair as its second word. A paired read at the top address returns word 0 as its second word, because the address wraps.
- R7: When req_valid is held high, a request is accepted on every clock. Each accepted read is answered in exactly the following cycle. A cycle with req_valid=0 yields rsp_valid=0 in the next cycle.
- R8: Each stored half carries an odd-parity bit, chosen so that the half and its parity bit together hold an odd number of ones. On a write, req_par_flip[0] inverts the parity stored with the low half and req_par_flip[1] inverts the parity stored with the high half. On a read, rsp_perr flags each half whose parity check fails: bit 0 for the low half of word 0, bit 1 for the high half of word 0, bit 2 for the low half of word 1, and bit 3 for the high half of word 1.
- R9: A parity error does not alter the data returned: rsp_data0 and rsp_data1 still carry the stored half-word values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Store can accept a request |
| req_write | input | 1 | 1 = write one word, 0 = read |
| req_pair | input | 1 | On a read, 1 = fetch words n and n+1 |
| req_addr | input | ADDR_W | Word address n |
| req_wdata | input | 2*HALF_W | Write word, high half in the upper bits |
| req_par_flip | input | 2 | Per-half parity inversion on write, for error injection |
| rsp_valid | output | 1 | Read result present |
| rsp_data0 | output | 2*HALF_W | Word n |
| rsp_data1 | output | 2*HALF_W | Word n+1 on a paired read, else 0 |
| rsp_perr | output | 4 | Per-half parity error flags |

## Verification
The bench builds the store with ADDR_W=8 and HALF_W=24. This gives 256 words, with a bank pair boundary between addresses 127 and 128. The whole store can be filled in a few hundred cycles. Random paired reads then land often on odd start addresses, on the pair boundary and on the wrapping top address. At full half-word width, a flipped parity bit shows up among data patterns that use all 24 bits of each half.

// File: rtl/icore_pkg.sv
package icore_pkg;

    // default geometry of the store
    localparam int unsigned HALF_W_DEF = 24;
    localparam int unsigned ADDR_W_DEF = 10;

    // the store is organised as two pairs of banks
    localparam int unsigned NBANK = 4;
    localparam int unsigned PERR_W = 4;

    // positions of the flags in the per-half error vector
    localparam int unsigned PE_W0_LO = 0;
    localparam int unsigned PE_W0_HI = 1;
    localparam int unsigned PE_W1_LO = 2;
    localparam int unsigned PE_W1_HI = 3;

endpackage

// File: rtl/icore_parity.sv
// Odd parity: returns the bit that makes (data, bit) contain an odd number of ones.
module icore_parity #(
    parameter int unsigned W = 24
) (
    input  logic [W-1:0] data,
    output logic         par
);
    assign par = ~(^data);
endmodule

// File: rtl/icore_bank.sv
// One storage bank: synchronous write, combinational read port.
module icore_bank #(
    parameter int unsigned ROW_W  = 8,
    parameter int unsigned CELL_W = 50
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ROW_W-1:0]  wrow,
    input  logic [CELL_W-1:0] wcell,
    input  logic [ROW_W-1:0]  rrow,
    output logic [CELL_W-1:0] rcell
);
    localparam int unsigned DEPTH = 1 << ROW_W;

    logic [CELL_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wrow] <= wcell;
        end
    end

    assign rcell = mem[rrow];
endmodule

// File: rtl/icore_store.sv
module icore_store
    import icore_pkg::*;
#(
    parameter int unsigned HALF_W = HALF_W_DEF,
    parameter int unsigned ADDR_W = ADDR_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic                  req_pair,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [2*HALF_W-1:0]   req_wdata,
    input  logic [1:0]            req_par_flip,
    output logic                  rsp_valid,
    output logic [2*HALF_W-1:0]   rsp_data0,
    output logic [2*HALF_W-1:0]   rsp_data1,
    output logic [PERR_W-1:0]     rsp_perr
);
    localparam int unsigned WORD_W = 2 * HALF_W;
    localparam int unsigned SLOT_W = HALF_W + 1;
    localparam int unsigned CELL_W = 2 * SLOT_W;
    localparam int unsigned ROW_W  = ADDR_W - 2;

    typedef struct packed {
        logic              ready;
        logic              vld;
        logic [WORD_W-1:0] d0;
        logic [WORD_W-1:0] d1;
        logic [PERR_W-1:0] perr;
    } st_t;

    st_t st_d, st_q;

    // address decode: top bit picks the pair, bit 0 picks the bank in the pair
    logic [ADDR_W-1:0] addr0, addr1;
    logic [1:0]        bank0, bank1;
    logic [ROW_W-1:0]  row0, row1;
    logic              accept;

    assign accept = req_valid & st_q.ready;
    assign addr0  = req_addr;
    assign addr1  = req_addr + ADDR_W'(1);
    assign bank0  = {addr0[ADDR_W-1], addr0[0]};
    assign bank1  = {addr1[ADDR_W-1], addr1[0]};
    assign row0   = addr0[ADDR_W-2:1];
    assign row1   = addr1[ADDR_W-2:1];

    // write cell: {par_hi, hi, par_lo, lo}
    logic              wpar_lo, wpar_hi;
    logic [CELL_W-1:0] wcell;

    icore_parity #(.W(HALF_W)) u_wpar_lo (.data(req_wdata[HALF_W-1:0]),      .par(wpar_lo));
    icore_parity #(.W(HALF_W)) u_wpar_hi (.data(req_wdata[WORD_W-1:HALF_W]), .par(wpar_hi));

    assign wcell = {wpar_hi ^ req_par_flip[1], req_wdata[WORD_W-1:HALF_W],
                    wpar_lo ^ req_par_flip[0], req_wdata[HALF_W-1:0]};

    // the four banks
    logic [NBANK-1:0]  bank_we;
    logic [CELL_W-1:0] rcell [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic SIDE = 1'(b % 2);
        logic [ROW_W-1:0] rrow;

        // the bank on word n's side serves n, the other side serves n+1
        assign rrow       = (SIDE == addr0[0]) ? row0 : row1;
        assign bank_we[b] = accept & req_write & (bank0 == 2'(b));

        icore_bank #(.ROW_W(ROW_W), .CELL_W(CELL_W)) u_bank (
            .clk   (clk),
            .we    (bank_we[b]),
            .wrow  (row0),
            .wcell (wcell),
            .rrow  (rrow),
            .rcell (rcell[b])
        );
    end

    // steer bank outputs so word n is always first
    logic [CELL_W-1:0] cell0, cell1;
    logic [SLOT_W-1:0] rd_slot [PERR_W];
    logic [PERR_W-1:0] bad;

    assign cell0 = rcell[bank0];
    assign cell1 = rcell[bank1];

    always_comb begin
        rd_slot[PE_W0_LO] = cell0[SLOT_W-1:0];
        rd_slot[PE_W0_HI] = cell0[CELL_W-1:SLOT_W];
        rd_slot[PE_W1_LO] = cell1[SLOT_W-1:0];
        rd_slot[PE_W1_HI] = cell1[CELL_W-1:SLOT_W];
    end

    for (genvar k = 0; k < PERR_W; k++) begin : g_chk
        logic exp_par;
        icore_parity #(.W(HALF_W)) u_rpar (.data(rd_slot[k][HALF_W-1:0]), .par(exp_par));
        assign bad[k] = rd_slot[k][HALF_W] ^ exp_par;
    end

    // next-state logic
    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b1;
        st_d.vld   = accept & ~req_write;
        if (accept && !req_write) begin
            st_d.d0             = {cell0[SLOT_W +: HALF_W], cell0[0 +: HALF_W]};
            st_d.perr[PE_W0_LO] = bad[PE_W0_LO];
            st_d.perr[PE_W0_HI] = bad[PE_W0_HI];
            if (req_pair) begin
                st_d.d1             = {cell1[SLOT_W +: HALF_W], cell1[0 +: HALF_W]};
                st_d.perr[PE_W1_LO] = bad[PE_W1_LO];
                st_d.perr[PE_W1_HI] = bad[PE_W1_HI];
            end else begin
                st_d.d1             = '0;
                st_d.perr[PE_W1_LO] = 1'b0;
                st_d.perr[PE_W1_HI] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = st_q.ready;
    assign rsp_valid = st_q.vld;
    assign rsp_data0 = st_q.d0;
    assign rsp_data1 = st_q.d1;
    assign rsp_perr  = st_q.perr;

    // R1: once ready, the store stays ready
    p_ready_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> req_ready);

    // R2: at most one bank written per cycle, and only on an accepted write
    p_one_writer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we) && ((bank_we != '0) -> (accept && req_write)));

    // R2 / R7: no response unless a read was accepted
    p_quiet_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && !req_write) |=> !rsp_valid);

    // R7: an accepted read is answered in the next cycle
    p_rsp_follows_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_write) |=> rsp_valid);

    // R3: a single read clears the second word and its flags
    p_single_clears_w1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_write && !req_pair) |=> (rsp_data1 == '0 && rsp_perr[3:2] == 2'b00));

    // R5: the two words of a pair always come from different banks
    p_pair_banks_differ_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_write && req_pair) |-> (bank0 != bank1));

endmodule

// File: tb/icore_store_tb_top.sv
module icore_store_tb_top;

    localparam int unsigned HALF_W     = 24;
    localparam int unsigned ADDR_W     = 8;
    localparam int unsigned WORD_W     = 2 * HALF_W;
    localparam int unsigned NWORDS     = 1 << ADDR_W;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned TOP_LOWER  = (NWORDS / 2) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic              req_pair = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [WORD_W-1:0] req_wdata = '0;
    logic [1:0]        req_par_flip = 2'b00;
    logic              rsp_valid;
    logic [WORD_W-1:0] rsp_data0;
    logic [WORD_W-1:0] rsp_data1;
    logic [3:0]        rsp_perr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [WORD_W-1:0] sh_data [NWORDS];
    logic [1:0]        sh_flip [NWORDS];

    always #(CLK_PERIOD / 2) clk = ~clk;

    icore_store #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_write    (req_write),
        .req_pair     (req_pair),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_par_flip (req_par_flip),
        .rsp_valid    (rsp_valid),
        .rsp_data0    (rsp_data0),
        .rsp_data1    (rsp_data1),
        .rsp_perr     (rsp_perr)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] rand_word();
        return {16'($urandom), 32'($urandom)};
    endfunction

    // requirement tag for the data checks of one read
    function automatic string read_tag(input logic pair, input logic [ADDR_W-1:0] a);
        if (!pair) return "R3";
        if (a == ADDR_W'(NWORDS - 1) || a == ADDR_W'(TOP_LOWER)) return "R6";
        if (a[0]) return "R5";
        return "R4";
    endfunction

    // one request cycle: drive at negedge, check the response one negedge later
    task automatic step(input logic v, input logic w, input logic p,
                        input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] wd,
                        input logic [1:0] fl, input string vtag);
        logic              exp_v;
        logic [WORD_W-1:0] e0, e1;
        logic [3:0]        epe;
        logic [ADDR_W-1:0] a1;
        a1 = a + ADDR_W'(1);
        chk("R1", "req_ready", 64'(req_ready), 64'd1);
        req_valid    = v;
        req_write    = w;
        req_pair     = p;
        req_addr     = a;
        req_wdata    = wd;
        req_par_flip = fl;
        exp_v = v && !w;
        e0    = sh_data[a];
        e1    = p ? sh_data[a1] : '0;
        epe   = {p ? sh_flip[a1] : 2'b00, sh_flip[a]};
        if (v && w) begin
            sh_data[a] = wd;
            sh_flip[a] = fl;
        end
        @(posedge clk);
        @(negedge clk);
        chk(vtag, "rsp_valid", 64'(rsp_valid), 64'(exp_v));
        if (exp_v) begin
            chk((epe != 0) ? "R9" : read_tag(p, a), "rsp_data0", 64'(rsp_data0), 64'(e0));
            chk((epe != 0) ? "R9" : read_tag(p, a), "rsp_data1", 64'(rsp_data1), 64'(e1));
            chk("R8", "rsp_perr", 64'(rsp_perr), 64'(epe));
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0C0E));
        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        chk("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        chk("R1", "req_ready in reset", 64'(req_ready), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "req_ready after reset", 64'(req_ready), 64'd1);

        // fill the store (R2), a few words with injected parity faults (R8)
        for (int i = 0; i < int'(NWORDS); i++) begin
            logic [1:0] fl;
            fl = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
            step(1'b1, 1'b1, 1'b0, ADDR_W'(i), rand_word(), fl, "R2");
        end

        // directed patterns
        step(1'b1, 1'b1, 1'b0, 8'd4,   48'hAAAAAA_555555, 2'b00, "R2");
        step(1'b1, 1'b1, 1'b0, 8'd5,   48'hFFFFFF_000000, 2'b00, "R2");
        step(1'b1, 1'b1, 1'b0, 8'd6,   48'h123456_789ABC, 2'b00, "R2");
        step(1'b1, 1'b1, 1'b0, 8'd10,  48'h0F0F0F_F0F0F0, 2'b01, "R2");
        step(1'b1, 1'b1, 1'b0, 8'd11,  48'h000001_800000, 2'b10, "R2");
        step(1'b1, 1'b1, 1'b0, 8'd127, 48'hDEAD01_BEEF02, 2'b00, "R2");
        step(1'b1, 1'b1, 1'b0, 8'd128, 48'hCAFE03_F00D04, 2'b00, "R2");
        step(1'b1, 1'b1, 1'b0, 8'd255, 48'h7777_77_888888, 2'b00, "R2");
        step(1'b1, 1'b1, 1'b0, 8'd0,   48'h000000_000000, 2'b00, "R2");

        step(1'b1, 1'b0, 1'b0, 8'd5,   '0, 2'b00, "R3");
        step(1'b1, 1'b0, 1'b1, 8'd4,   '0, 2'b00, "R4");
        step(1'b1, 1'b0, 1'b1, 8'd5,   '0, 2'b00, "R5");
        step(1'b1, 1'b0, 1'b1, 8'd127, '0, 2'b00, "R6");
        step(1'b1, 1'b0, 1'b1, 8'd255, '0, 2'b00, "R6");
        step(1'b1, 1'b0, 1'b1, 8'd10,  '0, 2'b00, "R8");
        step(1'b1, 1'b0, 1'b0, 8'd11,  '0, 2'b00, "R9");
        step(1'b0, 1'b0, 1'b0, 8'd4,   '0, 2'b00, "R7");
        step(1'b1, 1'b1, 1'b0, 8'd10,  48'h0F0F0F_F0F0F0, 2'b00, "R2");
        step(1'b1, 1'b0, 1'b1, 8'd9,   '0, 2'b00, "R5");

        // constrained random traffic, back-to-back (R7)
        for (int i = 0; i < 3000; i++) begin
            logic v, w, p;
            logic [1:0] fl;
            v  = ($urandom % 8) != 0;
            w  = ($urandom % 4) == 0;
            p  = ($urandom % 2) == 0;
            fl = (($urandom % 16) == 0) ? 2'($urandom) : 2'b00;
            step(v, w, p, 8'($urandom), rand_word(), fl, "R7");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule